// File: doc/BRIEF.md
# Transmit Timestamp Store with Ready Map

This block holds the transmit timestamps captured for one group of ports. A capture port writes a timestamp word into one of the entries of a store. Each word carries a meaningful-value flag in its top bit. A register read port lets software fetch any entry, or fetch the per-entry ready map as 32-bit words. Each ready bit goes high when its entry is captured and goes low when software reads that entry.

An internal pending counter rises by one on each capture and falls by one on each entry read, whether or not the entry was ready. It wraps at its width. The timestamp interrupt pulses when a capture lifts this counter from zero to one. A read of an entry that is not ready therefore pushes the counter below zero. Later captures can then fail to raise an interrupt. Software is expected to read only entries whose ready bit is set.

The read port has one cycle of latency, and its data path maps onto block RAM. A synchronous reset makes every entry read as zero, clears the ready map and zeroes the counter.

Top module: `txts_mem`

## Requirements
- R1: While `rst` is high, and on every cycle after it until a capture, every entry read returns zero, both map words return zero and `ts_irq` stays low.
- R2: A read strobe `rd_en` makes `rd_valid` high one cycle later with the data in `rd_data`. An entry read (`rd_addr` below N_ENTRY) returns the last word captured at that index.
- R3: A capture sets the ready bit of its index. Address N_ENTRY returns map bits 31..0 and address N_ENTRY+1 returns bits 63..32, each in `rd_data[31:0]` with the upper half zero.
- R4: An entry read clears that entry's ready bit. A map read changes neither the map nor the counter.
- R5: A read never alters a stored word. Reading the same entry again returns the same word until a new capture at that index overwrites it.
- R6: The 7-bit pending counter adds one per capture and subtracts one per entry read, ready or not, modulo 128. After a read of a non-ready entry from zero, the next capture raises no interrupt.
- R7: `ts_irq` is high for exactly one cycle, the cycle after a capture that moves the counter from zero to one.
- R8: A capture and an entry read in the same cycle leave the counter unchanged and raise no interrupt.
- R9: When a capture and an entry read name the same index in the same cycle, the read returns the previous word and the ready bit ends set.
- R10: Reads at addresses N_ENTRY+2 and above return zero and change neither the map nor the counter.
- R11: A stored word is {`cap_valid`, `cap_ts`}: bit 63 holds the meaningful-value flag and bits 62..0 hold the timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture strobe |
| cap_idx | input | IDX_W (6) | Entry written by the capture |
| cap_valid | input | 1 | Meaningful-value flag of the captured word |
| cap_ts | input | TS_W-1 (63) | Captured timestamp |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | IDX_W+1 (7) | Read address: entries, then map words |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | TS_W (64) | Read data |
| ts_irq | output | 1 | One-cycle timestamp interrupt pulse |

## Verification
The bench builds the block with its defaults: 64 entries of 64 bits and a 7-bit counter. This gives two 32-bit map words, so the bench can set a bit in each half. It can also reach the out-of-range region above address 65. The bench keeps its own model of the words, the ready map and the counter, and compares every read and every cycle of `ts_irq` with that model. It drives a spurious read from zero to take the counter to 127, then shows that the next capture is silent. It also covers same-cycle capture and read, both on different entries and on the same entry, and a reset in the middle of a run.

// File: rtl/txts_pkg.sv
package txts_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_ENTRY = 2'd1,
    ACC_MAP   = 2'd2
  } acc_e;
endpackage

// File: rtl/txts_ram.sv
module txts_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [W-1:0]     rdata
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] written_q;
  logic [W-1:0]     raw_q;
  logic             hit_q;

  // Plain array, no reset: maps onto block RAM, read-first on collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) raw_q <= mem[raddr];
  end

  // Reset cannot clear RAM, so a written flag per entry masks stale data
  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      hit_q     <= 1'b0;
    end else begin
      if (re) hit_q <= written_q[raddr];
      if (we) written_q[waddr] <= 1'b1;
    end
  end

  assign rdata = hit_q ? raw_q : '0;

  assert_fresh_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (re && !written_q[raddr]) |=> (rdata == '0));
endmodule

// File: rtl/txts_ready_map.sv
module txts_ready_map #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N-1:0]     map_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (set_en && set_idx == IDX_W'(i))      map_q[i] <= 1'b1;
        else if (clr_en && clr_idx == IDX_W'(i)) map_q[i] <= 1'b0;
      end
    end
  end

  assert_set_R3: assert property (@(posedge clk) disable iff (rst)
    set_en |=> map_q[$past(set_idx)]);
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !map_q[$past(clr_idx)]);
  assert_same_win_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_en && set_en && set_idx == clr_idx) |=> map_q[$past(clr_idx)]);
endmodule

// File: rtl/txts_pend_irq.sv
module txts_pend_irq #(
  parameter int CNT_W = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic irq
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= inc && !dec && (cnt_q == '0);
      if (inc && !dec)      cnt_q <= cnt_q + CNT_W'(1);
      else if (dec && !inc) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assert_up_R6: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  assert_down_R6: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_both_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (inc && dec) |=> ($stable(cnt_q) && !irq));
  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

// File: rtl/txts_mem.sv
module txts_mem
  import txts_pkg::*;
#(
  parameter int N_ENTRY = 64,
  parameter int TS_W    = 64,
  parameter int CNT_W   = 7,
  parameter int IDX_W   = $clog2(N_ENTRY),
  parameter int ADDR_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic              cap_valid,
  input  logic [TS_W-2:0]   cap_ts,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [TS_W-1:0]   rd_data,
  output logic              ts_irq
);
  localparam int NUM_MAP = (N_ENTRY + REG_W - 1) / REG_W;
  localparam int MAP_PAD = NUM_MAP * REG_W;

  logic [N_ENTRY-1:0] map_q;
  logic [MAP_PAD-1:0] map_pad;
  logic [TS_W-1:0]    ram_rdata;
  logic               entry_rd;
  logic               map_rd;
  logic [ADDR_W-1:0]  map_off;
  logic [REG_W-1:0]   map_word;
  logic [REG_W-1:0]   map_word_q;
  acc_e               kind_q;

  assign entry_rd = rd_en && (rd_addr < ADDR_W'(N_ENTRY));
  assign map_off  = rd_addr - ADDR_W'(N_ENTRY);
  assign map_rd   = rd_en && !entry_rd && (map_off < ADDR_W'(NUM_MAP));

  txts_ram #(.DEPTH(N_ENTRY), .W(TS_W), .IDX_W(IDX_W)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (cap_en),
    .waddr (cap_idx),
    .wdata ({cap_valid, cap_ts}),
    .re    (entry_rd),
    .raddr (rd_addr[IDX_W-1:0]),
    .rdata (ram_rdata)
  );

  txts_ready_map #(.N(N_ENTRY), .IDX_W(IDX_W)) u_map (
    .clk     (clk),
    .rst     (rst),
    .set_en  (cap_en),
    .set_idx (cap_idx),
    .clr_en  (entry_rd),
    .clr_idx (rd_addr[IDX_W-1:0]),
    .map_q   (map_q)
  );

  txts_pend_irq #(.CNT_W(CNT_W)) u_pend (
    .clk (clk),
    .rst (rst),
    .inc (cap_en),
    .dec (entry_rd),
    .irq (ts_irq)
  );

  generate
    if (MAP_PAD > N_ENTRY) begin : g_pad
      assign map_pad = {{(MAP_PAD - N_ENTRY){1'b0}}, map_q};
    end else begin : g_nopad
      assign map_pad = map_q;
    end
  endgenerate

  always_comb begin
    map_word = '0;
    for (int k = 0; k < NUM_MAP; k++) begin
      if (map_off == ADDR_W'(k)) map_word = map_pad[k*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      kind_q     <= ACC_NONE;
      map_word_q <= '0;
    end else begin
      rd_valid <= rd_en;
      if (entry_rd)    kind_q <= ACC_ENTRY;
      else if (map_rd) kind_q <= ACC_MAP;
      else             kind_q <= ACC_NONE;
      if (map_rd) map_word_q <= map_word;
    end
  end

  always_comb begin
    case (kind_q)
      ACC_ENTRY: rd_data = ram_rdata;
      ACC_MAP:   rd_data = {{(TS_W - REG_W){1'b0}}, map_word_q};
      default:   rd_data = '0;
    endcase
  end

  assert_rd_valid_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_oob_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !entry_rd && !map_rd) |=> (rd_data == '0));
endmodule

// File: tb/sim_txts_mem.sv
module sim_txts_mem;
  localparam int CLK_P = 10;
  localparam int N     = 64;

  logic        clk = 1'b0;
  logic        rst;
  logic        cap_en;
  logic [5:0]  cap_idx;
  logic        cap_valid;
  logic [62:0] cap_ts;
  logic        rd_en;
  logic [6:0]  rd_addr;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        ts_irq;

  int checks = 0;
  int errors = 0;

  logic [63:0] m_mem [N];
  logic [N-1:0] m_wr;
  logic [N-1:0] m_ready;
  logic [6:0]  m_cnt;

  always #(CLK_P/2) clk = ~clk;

  txts_mem u0 (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_idx(cap_idx),
    .cap_valid(cap_valid), .cap_ts(cap_ts), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .ts_irq(ts_irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_clear();
    m_wr = '0; m_ready = '0; m_cnt = '0;
    for (int i = 0; i < N; i++) m_mem[i] = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(ts_irq == 1'b0, "R1 irq in reset", {63'd0, ts_irq}, 64'd0);
    rst = 1'b0;
    model_clear();
  endtask

  // One cycle: drive at a negedge, check at the next negedge, update model
  task automatic step(input bit ce, input int ci, input bit cv, input logic [62:0] ct,
                      input bit re, input int ra, input string tag);
    logic [63:0] exp_d;
    bit er, exp_irq;
    er = re && (ra < N);
    exp_d = '0;
    if (er)               exp_d = m_wr[ra] ? m_mem[ra] : 64'd0;
    else if (re && ra == N)     exp_d = {32'd0, m_ready[31:0]};
    else if (re && ra == N + 1) exp_d = {32'd0, m_ready[63:32]};
    exp_irq = ce && !er && (m_cnt == 7'd0);
    cap_en = ce; cap_idx = 6'(ci); cap_valid = cv; cap_ts = ct;
    rd_en = re; rd_addr = 7'(ra);
    @(negedge clk);
    chk(rd_valid == re, {tag, " rd_valid (R2)"}, {63'd0, rd_valid}, {63'd0, re});
    if (re) chk(rd_data == exp_d, {tag, " rd_data"}, rd_data, exp_d);
    chk(ts_irq == exp_irq, {tag, " irq (R7)"}, {63'd0, ts_irq}, {63'd0, exp_irq});
    if (er) m_ready[ra] = 1'b0;
    if (ce) begin
      m_mem[ci] = {cv, ct}; m_wr[ci] = 1'b1; m_ready[ci] = 1'b1;
    end
    if (ce && !er) m_cnt = m_cnt + 7'd1;
    else if (er && !ce) m_cnt = m_cnt - 7'd1;
    cap_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic t_reset_state();
    step(0, 0, 0, '0, 1, 0,  "R1 entry0");
    step(0, 0, 0, '0, 1, 63, "R1 entry63");
    step(0, 0, 0, '0, 1, N,  "R1 map lo");
    step(0, 0, 0, '0, 1, N+1,"R1 map hi");
  endtask

  task automatic t_capture_read();
    step(1, 3, 1, 63'h1234, 0, 0, "R7 first capture");
    step(1, 40, 0, 63'h7abc, 0, 0, "R11 invalid capture");
    step(0, 0, 0, '0, 1, N,   "R3 map lo");
    chk(m_ready[31:0] == 32'h8, "R3 model lo", {32'd0, m_ready[31:0]}, 64'h8);
    step(0, 0, 0, '0, 1, N+1, "R3 map hi");
    step(0, 0, 0, '0, 1, 3,   "R2 R11 entry3 valid");
    chk(m_mem[3] == 64'h8000_0000_0000_1234, "R11 word", m_mem[3], 64'h8000_0000_0000_1234);
    step(0, 0, 0, '0, 1, 40,  "R11 entry40 flag clear");
  endtask

  task automatic t_clear_on_read();
    step(0, 0, 0, '0, 1, N,   "R4 map lo cleared");
    step(0, 0, 0, '0, 1, N+1, "R4 map hi cleared");
    step(0, 0, 0, '0, 1, N+1, "R4 map read no effect");
  endtask

  task automatic t_sticky();
    do_reset();
    step(1, 5, 1, 63'h55, 0, 0, "R5 cap");
    step(0, 0, 0, '0, 1, 5, "R5 read1");
    step(0, 0, 0, '0, 1, 5, "R5 read2 same word");
    step(1, 5, 1, 63'h66, 0, 0, "R5 overwrite");
    step(0, 0, 0, '0, 1, 5, "R5 new word");
  endtask

  task automatic t_desync();
    do_reset();
    step(0, 0, 0, '0, 1, 9, "R6 spurious read");
    step(1, 9, 1, 63'h9, 0, 0, "R6 silent capture");
    chk(m_cnt == 7'd0, "R6 wrapped to zero", {57'd0, m_cnt}, 64'd0);
    step(1, 10, 1, 63'ha, 0, 0, "R6 next capture fires");
  endtask

  task automatic t_same_cycle();
    do_reset();
    step(1, 20, 1, 63'h20, 1, 21, "R8 cap+read other");
    step(0, 0, 0, '0, 1, N, "R8 map after");
    step(1, 22, 1, 63'h22, 0, 0, "R8 next capture");
  endtask

  task automatic t_collision();
    do_reset();
    step(1, 7, 1, 63'hA, 0, 0, "R9 cap A");
    step(0, 0, 0, '0, 1, 7, "R9 read A");
    step(1, 7, 1, 63'hB, 1, 7, "R9 collide returns A");
    step(0, 0, 0, '0, 1, N, "R9 ready stays set");
    chk(m_ready[7] == 1'b1, "R9 model bit", {63'd0, m_ready[7]}, 64'd1);
    step(0, 0, 0, '0, 1, 7, "R9 now B");
  endtask

  task automatic t_out_of_range();
    do_reset();
    step(1, 33, 1, 63'h33, 0, 0, "R10 cap");
    step(0, 0, 0, '0, 1, 66,  "R10 addr66");
    step(0, 0, 0, '0, 1, 127, "R10 addr127");
    step(0, 0, 0, '0, 1, N+1, "R10 map hi intact");
    step(0, 0, 0, '0, 1, 33,  "R10 entry33");
    step(1, 34, 1, 63'h34, 0, 0, "R10 counter intact");
  endtask

  task automatic t_mid_reset();
    step(1, 1, 1, 63'h1, 0, 0, "R1 pre cap");
    do_reset();
    step(0, 0, 0, '0, 1, 1, "R1 entry cleared");
    step(0, 0, 0, '0, 1, N, "R1 map cleared");
    step(1, 2, 1, 63'h2, 0, 0, "R1 counter zeroed");
  endtask

  initial begin
    rst = 1'b1; cap_en = 0; cap_idx = 0; cap_valid = 0; cap_ts = 0;
    rd_en = 0; rd_addr = 0;
    model_clear();
    @(negedge clk);
    do_reset();
    t_reset_state();
    t_capture_read();
    t_clear_on_read();
    t_sticky();
    t_desync();
    t_same_cycle();
    t_collision();
    t_out_of_range();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule